// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Unit

This block is the multiply-accumulate datapath of a fixed-point signal-processing core. Each command multiplies two signed two's-complement operands and keeps the whole double-width product. Nothing is dropped from the low half, so fractional data keeps all of its precision. The product is written into a dedicated product register. On the following clock edge it is combined with an extended-width accumulator. The accumulator has guard bits above the product width, so that long runs of accumulations do not wrap.

Commands are issued one per cycle with a valid strobe and a 3-bit operation code. A small control word travels down the pipeline alongside the data. Because of this, back-to-back multiply-accumulate commands sustain one accumulation per cycle, and commands take effect on the accumulator in the order in which they were issued. A sticky flag reports signed overflow of the accumulator. A read-out command returns a snapshot of the accumulator as it stands after all earlier commands.

Top module: `frac_mac`

## Requirements
- R1: While reset is high and after it is released, the product register, the accumulator, the overflow flag, the read-out strobe and the read-out data are all zero until a command changes them.
- R2: Operation codes 2, 3, 4 and 5 are multiplying commands. For any of these accepted with `in_valid` high, `prod_o` equals the exact signed product `in_a * in_b` (2×OP_W bits, no truncation) from the first rising edge after the operands are presented. No other command changes `prod_o`.
- R3: Code 3 (multiply-accumulate) adds the product, sign-extended to ACC_W bits, to the accumulator on the second rising edge after the command is presented.
- R4: Code 4 (multiply-subtract) subtracts the sign-extended product from the accumulator on that same second edge.
- R5: Code 5 (clear-and-multiply) loads the accumulator with the sign-extended product on the second edge and clears the overflow flag.
- R6: Code 2 (multiply only), code 0 (no operation) and code 7 (reserved) leave the accumulator and the overflow flag unchanged.
- R7: Code 1 (clear) sets the accumulator to zero and clears the overflow flag on the second edge. It does not change the product register.
- R8: When an add or a subtract overflows the signed ACC_W-bit range, the accumulator wraps modulo 2^ACC_W and `ovf_o` is set.
- R9: Once set, `ovf_o` stays set through any sequence of commands until a clear (code 1) or a clear-and-multiply (code 5) takes effect.
- R10: Code 6 (read-out) raises `rd_valid_o` for exactly one cycle, on the second edge. At the same time `rd_data_o` takes the accumulator value that results from all earlier commands. `rd_data_o` holds its value between read-outs.
- R11: Commands issued on consecutive cycles each take effect, one accumulation per cycle, in issue order. A cycle with `in_valid` low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Command strobe |
| in_op | input | 3 | Operation code (0 nop, 1 clear, 2 multiply, 3 mac, 4 msub, 5 clear-and-multiply, 6 read-out, 7 reserved) |
| in_a | input | OP_W | Signed multiplicand |
| in_b | input | OP_W | Signed multiplier |
| prod_o | output | 2*OP_W | Product register |
| acc_o | output | ACC_W | Accumulator |
| ovf_o | output | 1 | Sticky signed-overflow flag |
| rd_valid_o | output | 1 | Read-out strobe |
| rd_data_o | output | ACC_W | Read-out snapshot of the accumulator |

## Verification
On every cycle the assertions check four things: the product register against the operands of the previous cycle, each accumulator action against the previous accumulator and product, the stickiness of the overflow flag, and the agreement of read-out data with the accumulator. Only the bench's scenarios can show behaviour that needs history. This covers the exact cycle at which a long run of accumulations crosses the positive or negative limit, the wrapped value left behind, and correct ordering when clears, loads and read-outs are interleaved back to back with accumulations. The bench runs a reduced-width configuration, so that every operand pair can be swept through both accumulate and subtract.

// File: rtl/frac_mac_pkg.sv
package frac_mac_pkg;

    // Operation codes seen on in_op
    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_CLR = 3'd1,
        OP_MPY = 3'd2,
        OP_MAC = 3'd3,
        OP_MSU = 3'd4,
        OP_LDM = 3'd5,
        OP_RD  = 3'd6,
        OP_RSV = 3'd7
    } mac_op_e;

    // What the accumulator stage does with a command
    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_ZERO,
        ACT_LOAD,
        ACT_ADD,
        ACT_SUB
    } acc_act_e;

    // Control word travelling alongside the product
    typedef struct packed {
        logic    vld;
        mac_op_e op;
    } stage_ctl_t;

    function automatic logic op_uses_mult(mac_op_e op);
        return (op == OP_MPY) || (op == OP_MAC) ||
               (op == OP_MSU) || (op == OP_LDM);
    endfunction

    function automatic acc_act_e op_action(mac_op_e op);
        case (op)
            OP_CLR:  return ACT_ZERO;
            OP_LDM:  return ACT_LOAD;
            OP_MAC:  return ACT_ADD;
            OP_MSU:  return ACT_SUB;
            default: return ACT_HOLD;
        endcase
    endfunction

endpackage

// File: rtl/fm_mult_stage.sv
module fm_mult_stage
    import frac_mac_pkg::*;
#(
    parameter int OP_W   = 17,
    parameter int PROD_W = 2 * OP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  mac_op_e           in_op,
    input  logic [OP_W-1:0]   in_a,
    input  logic [OP_W-1:0]   in_b,
    output stage_ctl_t        ctl_q,
    output logic [PROD_W-1:0] prod_q
);

    logic signed [PROD_W-1:0] a_ext;
    logic signed [PROD_W-1:0] b_ext;
    logic signed [PROD_W-1:0] prod_full;
    logic                     cap_prod;

    always_comb begin
        a_ext     = PROD_W'($signed(in_a));
        b_ext     = PROD_W'($signed(in_b));
        prod_full = a_ext * b_ext;
        cap_prod  = in_vld && op_uses_mult(in_op);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '{vld: 1'b0, op: OP_NOP};
            prod_q <= '0;
        end else begin
            ctl_q.vld <= in_vld;
            ctl_q.op  <= in_op;
            if (cap_prod)
                prod_q <= prod_full;
        end
    end

    AST_PROD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cap_prod |=> $stable(prod_q)); // R2

endmodule

// File: rtl/fm_acc_stage.sv
module fm_acc_stage
    import frac_mac_pkg::*;
#(
    parameter int PROD_W = 34,
    parameter int ACC_W  = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  stage_ctl_t        ctl,
    input  logic [PROD_W-1:0] prod,
    output logic [ACC_W-1:0]  acc_q,
    output logic              ovf_q
);

    localparam int MSB   = ACC_W - 1;
    localparam int GUARD = ACC_W - PROD_W;

    logic [ACC_W-1:0] prod_ext;
    logic [ACC_W-1:0] addend;
    logic [ACC_W-1:0] sum;
    logic             sum_ovf;
    acc_act_e         act;

    // Sign extension into the guard bits
    generate
        if (GUARD > 0) begin : g_guard
            assign prod_ext = {{GUARD{prod[PROD_W-1]}}, prod};
        end else begin : g_noguard
            assign prod_ext = prod[ACC_W-1:0];
        end
    endgenerate

    always_comb begin
        act     = ctl.vld ? op_action(ctl.op) : ACT_HOLD;
        addend  = (act == ACT_SUB) ? ~prod_ext : prod_ext;
        sum     = acc_q + addend + ACC_W'(act == ACT_SUB);
        sum_ovf = (acc_q[MSB] == addend[MSB]) && (sum[MSB] != acc_q[MSB]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            case (act)
                ACT_ZERO: begin
                    acc_q <= '0;
                    ovf_q <= 1'b0;
                end
                ACT_LOAD: begin
                    acc_q <= prod_ext;
                    ovf_q <= 1'b0;
                end
                ACT_ADD, ACT_SUB: begin
                    acc_q <= sum;
                    ovf_q <= ovf_q | sum_ovf;
                end
                default: begin
                    acc_q <= acc_q;
                    ovf_q <= ovf_q;
                end
            endcase
        end
    end

    AST_ACC_ADD: assert property (@(posedge clk) disable iff (rst)
        act == ACT_ADD |=> acc_q == $past(acc_q) + $past(prod_ext)); // R3
    AST_ACC_SUB: assert property (@(posedge clk) disable iff (rst)
        act == ACT_SUB |=> acc_q == $past(acc_q) - $past(prod_ext)); // R4
    AST_ACC_LOAD: assert property (@(posedge clk) disable iff (rst)
        act == ACT_LOAD |=> (acc_q == $past(prod_ext)) && !ovf_q); // R5
    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
        act == ACT_HOLD |=> $stable(acc_q) && $stable(ovf_q)); // R6
    AST_ACC_ZERO: assert property (@(posedge clk) disable iff (rst)
        act == ACT_ZERO |=> (acc_q == '0) && !ovf_q); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf_q && (act != ACT_ZERO) && (act != ACT_LOAD) |=> ovf_q); // R9

endmodule

// File: rtl/fm_readout.sv
module fm_readout
    import frac_mac_pkg::*;
#(
    parameter int ACC_W = 40
) (
    input  logic             clk,
    input  logic             rst,
    input  stage_ctl_t       ctl,
    input  logic [ACC_W-1:0] acc,
    output logic             rd_valid_q,
    output logic [ACC_W-1:0] rd_data_q
);

    logic take;

    always_comb take = ctl.vld && (ctl.op == OP_RD);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= take;
            if (take)
                rd_data_q <= acc;
        end
    end

    AST_RD_QUIET: assert property (@(posedge clk) disable iff (rst)
        !take |=> !rd_valid_q && $stable(rd_data_q)); // R10

endmodule

// File: rtl/frac_mac.sv
module frac_mac
    import frac_mac_pkg::*;
#(
    parameter int OP_W  = 17,
    parameter int ACC_W = 40
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [2:0]            in_op,
    input  logic [OP_W-1:0]       in_a,
    input  logic [OP_W-1:0]       in_b,
    output logic [2*OP_W-1:0]     prod_o,
    output logic [ACC_W-1:0]      acc_o,
    output logic                  ovf_o,
    output logic                  rd_valid_o,
    output logic [ACC_W-1:0]      rd_data_o
);

    localparam int PROD_W = 2 * OP_W;

    mac_op_e    op_in;
    stage_ctl_t s1_ctl;

    always_comb op_in = mac_op_e'(in_op);

    fm_mult_stage #(.OP_W(OP_W), .PROD_W(PROD_W)) u_mult (
        .clk    (clk),
        .rst    (rst),
        .in_vld (in_valid),
        .in_op  (op_in),
        .in_a   (in_a),
        .in_b   (in_b),
        .ctl_q  (s1_ctl),
        .prod_q (prod_o)
    );

    fm_acc_stage #(.PROD_W(PROD_W), .ACC_W(ACC_W)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .ctl   (s1_ctl),
        .prod  (prod_o),
        .acc_q (acc_o),
        .ovf_q (ovf_o)
    );

    fm_readout #(.ACC_W(ACC_W)) u_rd (
        .clk        (clk),
        .rst        (rst),
        .ctl        (s1_ctl),
        .acc        (acc_o),
        .rd_valid_q (rd_valid_o),
        .rd_data_q  (rd_data_o)
    );

    AST_PROD_FULL: assert property (@(posedge clk) disable iff (rst)
        in_valid && op_uses_mult(op_in) |=>
            $signed(prod_o) == $signed(PROD_W'($signed($past(in_a))))
                             * $signed(PROD_W'($signed($past(in_b))))); // R2
    AST_RD_MATCH: assert property (@(posedge clk) disable iff (rst)
        rd_valid_o |-> rd_data_o == acc_o); // R10

endmodule

// File: tb/sim_frac_mac.sv
`timescale 1ns/1ps
module sim_frac_mac;
    import frac_mac_pkg::*;

    localparam int OPW  = 5;
    localparam int ACCW = 14;
    localparam int PW   = 2 * OPW;
    localparam int AMIN = -(1 << (OPW - 1));
    localparam int AMAX = (1 << (OPW - 1)) - 1;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic [2:0]      in_op = 3'd0;
    logic [OPW-1:0]  in_a = '0;
    logic [OPW-1:0]  in_b = '0;
    logic [PW-1:0]   prod_o;
    logic [ACCW-1:0] acc_o;
    logic            ovf_o;
    logic            rd_valid_o;
    logic [ACCW-1:0] rd_data_o;

    frac_mac #(.OP_W(OPW), .ACC_W(ACCW)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_a(in_a), .in_b(in_b), .prod_o(prod_o), .acc_o(acc_o),
        .ovf_o(ovf_o), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
    );

    always #2 clk = ~clk;

    int ntests = 0;
    int nfail  = 0;
    bit done   = 1'b0;

    // Bench model state
    longint m_prod = 0, m_acc = 0, m_rd = 0;
    bit     m_ovf = 1'b0, m_rdv = 1'b0;
    bit     p_v = 1'b0;
    logic [2:0] p_op = 3'd0;

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        ntests++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic bit is_mult(input logic [2:0] op);
        return op == 3'd2 || op == 3'd3 || op == 3'd4 || op == 3'd5;
    endfunction

    function automatic longint wrap_acc(input longint s);
        logic [ACCW-1:0] t;
        t = s[ACCW-1:0];
        return longint'($signed(t));
    endfunction

    task automatic model_stage2();
        longint s;
        m_rdv = p_v && (p_op == 3'd6);
        if (m_rdv) m_rd = m_acc;
        if (p_v) begin
            case (p_op)
                3'd1: begin m_acc = 0; m_ovf = 1'b0; end
                3'd5: begin m_acc = m_prod; m_ovf = 1'b0; end
                3'd3, 3'd4: begin
                    s = (p_op == 3'd3) ? m_acc + m_prod : m_acc - m_prod;
                    m_acc = wrap_acc(s);
                    if (s != m_acc) m_ovf = 1'b1;
                end
                default: ;
            endcase
        end
    endtask

    task automatic cyc(input logic [2:0] op, input int a, input int b, input bit v, input string tag);
        in_valid = v;
        in_op    = op;
        in_a     = a[OPW-1:0];
        in_b     = b[OPW-1:0];
        @(posedge clk);
        model_stage2();
        if (v && is_mult(op)) m_prod = longint'(a) * longint'(b);
        p_v  = v;
        p_op = op;
        @(negedge clk);
        check(tag, "prod_o", longint'($signed(prod_o)), m_prod);
        check(tag, "acc_o", longint'($signed(acc_o)), m_acc);
        check(tag, "ovf_o", longint'(ovf_o), longint'(m_ovf));
        check(tag, "rd_valid_o", longint'(rd_valid_o), longint'(m_rdv));
        check(tag, "rd_data_o", longint'($signed(rd_data_o)), m_rd);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", ntests, nfail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "acc_o in reset", longint'(acc_o), 0);
        check("R1", "prod_o in reset", longint'(prod_o), 0);
        rst = 1'b0;
        cyc(3'd0, 0, 0, 1'b0, "R1");
        cyc(3'd0, 0, 0, 1'b0, "R1");

        // R2 R3 R11: exhaustive back-to-back multiply-accumulate sweep
        cyc(3'd1, 0, 0, 1'b1, "R7");
        for (int a = AMIN; a <= AMAX; a++)
            for (int b = AMIN; b <= AMAX; b++)
                cyc(3'd3, a, b, 1'b1, "R3");
        cyc(3'd6, 0, 0, 1'b1, "R10");
        cyc(3'd0, 0, 0, 1'b0, "R10");

        // R4: exhaustive multiply-subtract sweep after a clear
        cyc(3'd1, 0, 0, 1'b1, "R7");
        for (int a = AMIN; a <= AMAX; a++)
            for (int b = AMIN; b <= AMAX; b++)
                cyc(3'd4, a, b, 1'b1, "R4");
        cyc(3'd0, 0, 0, 1'b0, "R4");

        // R5 R6 R11: load, then multiply-only, nop, reserved, idle
        cyc(3'd5, 7, -3, 1'b1, "R5");
        cyc(3'd2, 15, 15, 1'b1, "R6");
        cyc(3'd0, 9, 9, 1'b1, "R6");
        cyc(3'd7, 4, 4, 1'b1, "R6");
        cyc(3'd3, 5, 5, 1'b0, "R11");
        cyc(3'd6, 0, 0, 1'b1, "R10");
        cyc(3'd0, 0, 0, 1'b0, "R10");
        check("R5", "acc after load/mpy/nop", longint'($signed(acc_o)), -21);
        check("R6", "prod after mpy only", longint'($signed(prod_o)), 225);

        // R8: positive overflow after 32 products of 256
        cyc(3'd5, AMIN, AMIN, 1'b1, "R8");
        for (int i = 0; i < 31; i++) cyc(3'd3, AMIN, AMIN, 1'b1, "R8");
        check("R8", "ovf before limit", longint'(ovf_o), 0);
        check("R8", "acc before limit", longint'($signed(acc_o)), 7936);
        cyc(3'd0, 0, 0, 1'b0, "R8");
        check("R8", "ovf at limit", longint'(ovf_o), 1);
        check("R8", "wrapped acc", longint'($signed(acc_o)), -8192);

        // R9: sticky through mac, msub, mpy, read-out
        cyc(3'd4, 1, 1, 1'b1, "R9");
        cyc(3'd3, 0, 0, 1'b1, "R9");
        cyc(3'd2, 3, 3, 1'b1, "R9");
        cyc(3'd6, 0, 0, 1'b1, "R9");
        cyc(3'd0, 0, 0, 1'b0, "R9");
        check("R9", "ovf still set", longint'(ovf_o), 1);
        cyc(3'd1, 0, 0, 1'b1, "R7");
        cyc(3'd0, 0, 0, 1'b0, "R7");
        check("R7", "ovf cleared", longint'(ovf_o), 0);
        check("R7", "prod kept by clear", longint'($signed(prod_o)), 9);

        // R8: negative limit reached exactly, then crossed
        for (int i = 0; i < 32; i++) cyc(3'd4, AMIN, AMIN, 1'b1, "R8");
        cyc(3'd0, 0, 0, 1'b0, "R8");
        check("R8", "ovf at negative limit", longint'(ovf_o), 0);
        check("R8", "acc at negative limit", longint'($signed(acc_o)), -8192);
        cyc(3'd4, 1, 1, 1'b1, "R8");
        cyc(3'd0, 0, 0, 1'b0, "R8");
        check("R8", "ovf past negative limit", longint'(ovf_o), 1);
        check("R8", "wrapped negative acc", longint'($signed(acc_o)), 8191);

        // R5 R9 R10 R11: load clears flag; interleaved ops back to back
        cyc(3'd5, -2, 3, 1'b1, "R5");
        cyc(3'd6, 0, 0, 1'b1, "R10");
        cyc(3'd3, 4, 4, 1'b1, "R11");
        cyc(3'd6, 0, 0, 1'b1, "R10");
        cyc(3'd1, 0, 0, 1'b1, "R11");
        cyc(3'd6, 0, 0, 1'b1, "R10");
        cyc(3'd0, 0, 0, 1'b0, "R10");
        cyc(3'd0, 0, 0, 1'b0, "R10");
        check("R10", "rd_data held", longint'($signed(rd_data_o)), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

endmodule